// File: doc/BRIEF.md
# Page Array Program and Erase Engine

This block is the storage side of a small-page NAND device model. It keeps the page array in on-chip memory. Each page holds 512 data bytes followed by a spare area one thirty-second of that size (16 bytes), so consecutive pages sit 528 bytes apart. The front-end command decoder hands it one request at a time: program, erase or page load. Each request carries a byte address and a column offset. For a program the engine pulls bytes from the decoder's page buffer. For a load it fills that buffer from the array.

Work proceeds one byte per clock. `busy` stays high from the cycle after a request is taken until the operation finishes. A single-cycle `done` then marks the end. Requests that arrive while `busy` is high are dropped. Programming merges new data with a bitwise AND, so it can only clear bits. Only an erase, which works on a whole aligned block including its spare bytes, brings bits back to one.

The geometry constants live in the package. The default build has 4 pages in blocks of 2 pages, and the page-number field of the address is 4 bits wide, so pages 4 to 15 can be addressed but do not exist.

Top module: `nand_pe_engine`

## Requirements
- R1: From reset release, `busy` stays high while the engine writes 0xFF to every data and spare byte of the array, and `done` does not pulse. After that, a load of any page returns 528 bytes of 0xFF.
- R2: A program op code 1 changes array bytes as follows, for buffer index i from 0 up to `reqLen` - 1. The array byte at page*528 + column + `reqOffset` + i becomes its old value ANDed with buffer byte i. All other array bytes keep their values.
- R3: The page number is `reqAddr[11:8]` and the column is `reqAddr[7:0]`. The column is used by program only. Load and erase ignore it.
- R4: A program stops at the last spare byte of its page (index 527 within the page), whatever `reqLen` asks for. If column + offset is 528 or more, nothing is written.
- R5: An erase op code 2 clears the low page-in-block bits of the page number to find the block base. It then writes 0xFF to all 2*528 bytes of that block. Other blocks keep their values.
- R6: Any op whose page number is 4 or more changes neither the array nor the buffer. It still ends with a `done` pulse one cycle after it is taken.
- R7: A load op code 3 writes buffer index j with the array byte at page*528 + `reqOffset` + j, for j from 0 to 527 - `reqOffset`. Buffer indices above that keep their values.
- R8: A load whose `reqOffset` is 528 or more writes nothing to the buffer.
- R9: An op that moves n bytes keeps `busy` high for exactly n+1 cycles after the cycle in which it is taken. `done` is high in the cycle after the last of those, and for one cycle only.
- R10: A request presented while `busy` is high has no effect on the array or on the running op.
- R11: `offsetClr` pulses together with `done` at the end of every program whose page is in range, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; starts the array fill |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqOp | input | 2 | 1 program, 2 erase, 3 load, 0 none |
| reqAddr | input | 12 | Byte address: page in [11:8], column in [7:0] |
| reqOffset | input | 10 | Column offset added to the start position |
| reqLen | input | 11 | Number of buffer bytes to program |
| busy | output | 1 | Operation or reset fill in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| offsetClr | output | 1 | Tells the decoder to zero its read-start offset |
| bufAddr | output | 10 | Page buffer byte address |
| bufWrData | output | 8 | Page buffer write data |
| bufWe | output | 1 | Page buffer write enable |
| bufRdData | input | 8 | Page buffer read data, one cycle after the address |

## Verification
The bench goes after the start-position arithmetic, which adds column and offset. If the engine dropped the offset or mis-split the address, the wrong bytes would be cleared. That shows up when every page is read back and compared with the bench model. A program that runs into the spare end checks the clip: an engine without it would clear bytes at the start of the next page. The out-of-range cases are tested for all three ops. An engine that wrapped the page number would corrupt pages 0 to 3. It might also miss the trailing `done`, or raise `offsetClr` when it should not. A second request held during an erase checks that late requests are dropped. An engine that latched it would leave zeros in a page that must stay erased.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;

  // geometry
  parameter int PAGE_DATA   = 512;
  parameter int SPARE_BYTES = PAGE_DATA / 32;
  parameter int STRIDE      = PAGE_DATA + SPARE_BYTES;
  parameter int PAGE_COUNT  = 4;
  parameter int BLOCK_PAGES = 2;
  parameter int COL_BITS    = 8;
  parameter int PAGE_FIELD  = 4;

  // derived widths
  parameter int ADDR_W    = COL_BITS + PAGE_FIELD;
  parameter int ARR_BYTES = STRIDE * PAGE_COUNT;
  parameter int ARR_AW    = $clog2(ARR_BYTES);
  parameter int BUF_AW    = $clog2(STRIDE);
  parameter int LEN_W     = BUF_AW + 1;
  parameter int CNT_W     = ARR_AW + 1;
  parameter int ERASE_N   = BLOCK_PAGES * STRIDE;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_PROGRAM = 2'd1,
    OP_ERASE   = 2'd2,
    OP_LOAD    = 2'd3
  } opT;

  // strobes from control to datapath
  typedef struct packed {
    logic              arrWe;
    logic              fill;
    logic [ARR_AW-1:0] arrRAddr;
    logic [ARR_AW-1:0] arrWAddr;
    logic              bufWe;
    logic [BUF_AW-1:0] bufAddr;
  } strobeT;

endpackage

// File: rtl/nand_pe_array.sv
module nand_pe_array #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [7:0]    wData,
  input  logic [AW-1:0] rAddr,
  output logic [7:0]    rData
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    rData <= mem[rAddr];
  end

endmodule

// File: rtl/nand_pe_datapath.sv
module nand_pe_datapath
  import nand_pe_pkg::*;
(
  input  logic       clk,
  input  strobeT     strobe,
  input  logic [7:0] bufRdData,
  output logic [7:0] bufWrData
);

  logic [7:0] arrRdData;
  logic [7:0] arrWrData;

  // erase and reset fill write ones; program merges by AND
  always_comb begin
    if (strobe.fill) arrWrData = 8'hFF;
    else             arrWrData = arrRdData & bufRdData;
  end

  assign bufWrData = arrRdData;

  nand_pe_array #(
    .DEPTH(ARR_BYTES),
    .AW   (ARR_AW)
  ) i_array (
    .clk  (clk),
    .we   (strobe.arrWe),
    .wAddr(strobe.arrWAddr),
    .wData(arrWrData),
    .rAddr(strobe.arrRAddr),
    .rData(arrRdData)
  );

endmodule

// File: rtl/nand_pe_ctrl.sv
module nand_pe_ctrl
  import nand_pe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  opT                reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUF_AW-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  output strobeT            strobe,
  output logic              busy,
  output logic              done,
  output logic              offsetClr
);

  typedef enum logic {ST_IDLE, ST_RUN} stT;

  localparam logic [ARR_AW-1:0] STRIDE_A = ARR_AW'(STRIDE);
  localparam logic [BUF_AW:0]   STRIDE_S = (BUF_AW+1)'(STRIDE);

  stT                state;
  opT                curOp;
  logic              quiet;
  logic              clrPending;
  logic [ARR_AW-1:0] arrPtr;
  logic [BUF_AW-1:0] bufPtr;
  logic [CNT_W-1:0]  remain;
  logic              s1Valid;
  logic [ARR_AW-1:0] s1ArrAddr;
  logic [BUF_AW-1:0] s1BufIdx;

  // request decode
  logic [PAGE_FIELD-1:0] reqPage;
  logic [COL_BITS-1:0]   reqCol;
  logic                  inRange;
  logic [ARR_AW-1:0]     pageBase;
  logic [ARR_AW-1:0]     blockBase;
  logic [BUF_AW:0]       progStart;
  logic [BUF_AW:0]       loadStart;
  logic [CNT_W-1:0]      progRoom;
  logic [CNT_W-1:0]      progCount;
  logic [CNT_W-1:0]      loadCount;
  logic [CNT_W-1:0]      acceptCount;
  logic [ARR_AW-1:0]     acceptPtr;
  logic                  accept;

  assign reqPage   = reqAddr[ADDR_W-1:COL_BITS];
  assign reqCol    = reqAddr[COL_BITS-1:0];
  assign inRange   = int'(reqPage) < PAGE_COUNT;
  assign pageBase  = ARR_AW'(reqPage) * STRIDE_A;
  assign blockBase = ARR_AW'(reqPage & ~PAGE_FIELD'(BLOCK_PAGES - 1)) * STRIDE_A;
  assign progStart = (BUF_AW+1)'(reqCol) + (BUF_AW+1)'(reqOffset);
  assign loadStart = {1'b0, reqOffset};
  assign progRoom  = (progStart >= STRIDE_S) ? '0 : CNT_W'(STRIDE_S - progStart);
  assign progCount = (CNT_W'(reqLen) < progRoom) ? CNT_W'(reqLen) : progRoom;
  assign loadCount = (loadStart >= STRIDE_S) ? '0 : CNT_W'(STRIDE_S - loadStart);
  assign accept    = (state == ST_IDLE) && reqValid && (reqOp != OP_NONE);

  always_comb begin
    acceptCount = '0;
    acceptPtr   = '0;
    case (reqOp)
      OP_PROGRAM: begin
        acceptCount = progCount;
        acceptPtr   = pageBase + ARR_AW'(progStart);
      end
      OP_ERASE: begin
        acceptCount = CNT_W'(ERASE_N);
        acceptPtr   = blockBase;
      end
      OP_LOAD: begin
        acceptCount = loadCount;
        acceptPtr   = pageBase + ARR_AW'(loadStart);
      end
      default: ;
    endcase
    if (!inRange) acceptCount = '0;
  end

  // sequencing: reset starts a quiet fill of the whole array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      curOp      <= OP_ERASE;
      quiet      <= 1'b1;
      clrPending <= 1'b0;
      arrPtr     <= '0;
      bufPtr     <= '0;
      remain     <= CNT_W'(ARR_BYTES);
      s1Valid    <= 1'b0;
      s1ArrAddr  <= '0;
      s1BufIdx   <= '0;
      done       <= 1'b0;
      offsetClr  <= 1'b0;
    end else begin
      done      <= 1'b0;
      offsetClr <= 1'b0;
      s1Valid   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_RUN;
            curOp      <= reqOp;
            quiet      <= 1'b0;
            clrPending <= (reqOp == OP_PROGRAM) && inRange;
            arrPtr     <= acceptPtr;
            bufPtr     <= '0;
            remain     <= acceptCount;
          end
        end
        default: begin
          if (remain != '0) begin
            s1Valid   <= 1'b1;
            s1ArrAddr <= arrPtr;
            s1BufIdx  <= bufPtr;
            arrPtr    <= arrPtr + 1'b1;
            bufPtr    <= bufPtr + 1'b1;
            remain    <= remain - 1'b1;
          end else begin
            state     <= ST_IDLE;
            done      <= !quiet;
            offsetClr <= clrPending && !quiet;
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_RUN);

  always_comb begin
    strobe          = '0;
    strobe.arrRAddr = arrPtr;
    strobe.arrWAddr = s1ArrAddr;
    strobe.fill     = (curOp != OP_PROGRAM);
    strobe.arrWe    = s1Valid && (curOp != OP_LOAD);
    strobe.bufWe    = s1Valid && (curOp == OP_LOAD);
    strobe.bufAddr  = (curOp == OP_LOAD) ? s1BufIdx : bufPtr;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R9
  AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(curOp)); // R10
  AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    offsetClr |-> done); // R11

endmodule

// File: rtl/nand_pe_engine.sv
module nand_pe_engine
  import nand_pe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUF_AW-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  output logic              offsetClr,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [7:0]        bufWrData,
  output logic              bufWe,
  input  logic [7:0]        bufRdData
);

  strobeT strobe;

  nand_pe_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (opT'(reqOp)),
    .reqAddr  (reqAddr),
    .reqOffset(reqOffset),
    .reqLen   (reqLen),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .offsetClr(offsetClr)
  );

  nand_pe_datapath i_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .bufRdData(bufRdData),
    .bufWrData(bufWrData)
  );

  assign bufAddr = strobe.bufAddr;
  assign bufWe   = strobe.bufWe;

  AST_LOAD_LEAVES_ARRAY: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> !strobe.arrWe); // R7
  AST_WRITE_IN_ARRAY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arrWe |-> int'(strobe.arrWAddr) < ARR_BYTES); // R4
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strobe.arrWe && !bufWe); // R6

endmodule

// File: tb/test_nand_pe_engine.sv
`timescale 1ns/1ps
module test_nand_pe_engine;
  import nand_pe_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [BUF_AW-1:0] reqOffset = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic              busy, done, offsetClr, bufWe;
  logic [BUF_AW-1:0] bufAddr;
  logic [7:0]        bufWrData;
  logic [7:0]        bufRdData = 8'h00;

  logic [7:0] bufMem [STRIDE];
  logic [7:0] model  [ARR_BYTES];

  int testCount = 0;
  int failCount = 0;
  int cycleCnt  = 0;
  int doneCount = 0;

  always #2.5 clk = ~clk;

  nand_pe_engine i_nand_pe_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqOffset(reqOffset), .reqLen(reqLen),
    .busy(busy), .done(done), .offsetClr(offsetClr),
    .bufAddr(bufAddr), .bufWrData(bufWrData), .bufWe(bufWe),
    .bufRdData(bufRdData)
  );

  // page buffer: synchronous byte RAM
  always @(posedge clk) begin
    if (int'(bufAddr) < STRIDE) begin
      bufRdData <= bufMem[bufAddr];
      if (bufWe) bufMem[bufAddr] <= bufWrData;
    end
  end

  always @(posedge clk) begin
    cycleCnt++;
    if (rstN && done) doneCount++;
    if (cycleCnt > 150000) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycleCnt);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runOp(input int op, input int page, input int col, input int off,
                       input int len, output int cyc, output bit clr);
    @(negedge clk);
    reqValid  = 1'b1;
    reqOp     = 2'(op);
    reqAddr   = {PAGE_FIELD'(page), COL_BITS'(col)};
    reqOffset = BUF_AW'(off);
    reqLen    = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    clr = offsetClr;
    @(negedge clk);
    check(!done, "R9", "done width", int'(done), 0);
  endtask

  function automatic int progBytes(int page, int col, int off, int len);
    int start = col + off;
    if (page >= PAGE_COUNT || start >= STRIDE) return 0;
    return (len < STRIDE - start) ? len : STRIDE - start;
  endfunction

  function automatic void modelProgram(int page, int col, int off, int len);
    int n = progBytes(page, col, off, len);
    for (int i = 0; i < n; i++)
      model[page*STRIDE + col + off + i] = model[page*STRIDE + col + off + i] & bufMem[i];
  endfunction

  function automatic void modelErase(int page);
    if (page < PAGE_COUNT) begin
      int base = (page / BLOCK_PAGES) * BLOCK_PAGES * STRIDE;
      for (int i = 0; i < ERASE_N; i++) model[base + i] = 8'hFF;
    end
  endfunction

  task automatic dumpCheck(input string req);
    int cyc, bad, firstA, firstE;
    bit clr;
    for (int p = 0; p < PAGE_COUNT; p++) begin
      runOp(3, p, 0, 0, 0, cyc, clr);
      check(cyc == STRIDE + 1, "R9", "load cycles", cyc, STRIDE + 1);
      bad = 0; firstA = 0; firstE = 0;
      for (int j = 0; j < STRIDE; j++)
        if (bufMem[j] !== model[p*STRIDE + j]) begin
          if (bad == 0) begin firstA = int'(bufMem[j]); firstE = int'(model[p*STRIDE + j]); end
          bad++;
        end
      check(bad == 0, req, $sformatf("page %0d readback first byte", p), firstA, firstE);
    end
  endtask

  initial begin
    int cyc, n;
    bit clr;
    for (int i = 0; i < ARR_BYTES; i++) model[i] = 8'hFF;
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'h00;

    // R1: reset fill
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R1", "busy after release", int'(busy), 1);
    while (busy) @(negedge clk);
    check(doneCount == 0, "R1", "done pulses during fill", doneCount, 0);
    dumpCheck("R1");

    // R2, R3: program sweep over pages, columns and offsets
    for (int p = 0; p < PAGE_COUNT; p++)
      for (int k = 0; k < 3; k++) begin
        int col = k*20 + p;
        int off = (k == 1) ? 256 : 0;
        int len = 60 + k*40;
        for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'((i*7 + p*13 + k*29) ^ 8'hC3);
        n = progBytes(p, col, off, len);
        runOp(1, p, col, off, len, cyc, clr);
        check(cyc == n + 1, "R9", "program cycles", cyc, n + 1);
        check(clr == 1'b1, "R11", "offset clear", int'(clr), 1);
        modelProgram(p, col, off, len);
      end
    dumpCheck("R2");
    // overlapping second pass on page 1 shows AND merging
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'(i ^ 8'h5A);
    runOp(1, 1, 16, 256, 200, cyc, clr);
    modelProgram(1, 16, 256, 200);
    dumpCheck("R3");

    // R4: clip at spare end, and start past the page
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'h00;
    runOp(1, 1, 200, 256, 300, cyc, clr);
    check(cyc == 73, "R4", "clipped program cycles", cyc, 73);
    modelProgram(1, 200, 256, 300);
    runOp(1, 2, 255, 300, 50, cyc, clr);
    check(cyc == 1, "R4", "past-end program cycles", cyc, 1);
    check(clr == 1'b1, "R11", "offset clear past end", int'(clr), 1);
    dumpCheck("R4");

    // R5: erase of page 3 clears block of pages 2 and 3 only
    runOp(2, 3, 8'h55, 0, 0, cyc, clr);
    check(cyc == ERASE_N + 1, "R5", "erase cycles", cyc, ERASE_N + 1);
    check(clr == 1'b0, "R11", "no clear on erase", int'(clr), 0);
    modelErase(3);
    dumpCheck("R5");

    // R6: out-of-range pages
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'hA7;
    runOp(1, 5, 0, 0, 100, cyc, clr);
    check(cyc == 1, "R6", "program oor cycles", cyc, 1);
    check(clr == 1'b0, "R11", "no clear oor", int'(clr), 0);
    runOp(2, 9, 0, 0, 0, cyc, clr);
    check(cyc == 1, "R6", "erase oor cycles", cyc, 1);
    runOp(3, 12, 0, 0, 0, cyc, clr);
    check(cyc == 1, "R6", "load oor cycles", cyc, 1);
    n = 0;
    for (int i = 0; i < STRIDE; i++) if (bufMem[i] !== 8'hA7) n++;
    check(n == 0, "R6", "buffer bytes changed", n, 0);
    dumpCheck("R6");

    // R7: load with offset
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'h3C;
    runOp(3, 0, 8'h77, 300, 0, cyc, clr);
    check(cyc == STRIDE - 300 + 1, "R7", "offset load cycles", cyc, STRIDE - 300 + 1);
    n = 0;
    for (int j = 0; j < STRIDE; j++)
      if (j < STRIDE - 300) begin
        if (bufMem[j] !== model[300 + j]) n++;
      end else if (bufMem[j] !== 8'h3C) n++;
    check(n == 0, "R7", "offset load mismatches", n, 0);

    // R8: load offset beyond page
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'h3C;
    runOp(3, 1, 0, 600, 0, cyc, clr);
    check(cyc == 1, "R8", "far load cycles", cyc, 1);
    n = 0;
    for (int i = 0; i < STRIDE; i++) if (bufMem[i] !== 8'h3C) n++;
    check(n == 0, "R8", "buffer bytes changed", n, 0);

    // R10: request held during an erase is dropped
    for (int i = 0; i < STRIDE; i++) bufMem[i] = 8'h00;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd2; reqAddr = {PAGE_FIELD'(0), 8'h00};
    @(negedge clk);
    reqOp = 2'd1; reqAddr = {PAGE_FIELD'(2), 8'h00}; reqOffset = '0; reqLen = LEN_W'(100);
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R10", "still erasing", int'(busy), 1);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R10", "idle after erase", int'(busy), 0);
    modelErase(0);
    dumpCheck("R10");

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule